// File: doc/BRIEF.md
# Multiframe Q-Bit Double Buffer

This block holds the 4-bit Q value that a line interface sends uplink, one bit per frame, on the Q-channel of a multiframed link. A control-channel decoder delivers new Q values with a write strobe. Each write lands in a shadow register and sets a pending flag. The active register, which feeds the line, takes the shadow contents only at the first clock of a multiframe-start strobe. An update therefore never splits one multiframe between an old value and a new one.

Q bits go out only while multiframing is enabled and multiframe synchronization is held. At all other times the output carries the idle value 1 and the valid flag is low. While multiframing is disabled, writes are discarded. A loss of synchronization keeps any pending shadow value, and that value is applied at the first multiframe start after synchronization returns.

Top module: `qchan_dbuf`

## Requirements
- R1: After reset, `q_valid` is 0 and `q_bit` is 1. The shadow and active registers both hold all ones and nothing is pending, so a synchronized multiframe with no writes sends only 1 bits.
- R2: `q_valid` equals `mf_en AND mf_sync` of the previous clock, with a latency of one register.
- R3: Whenever `q_valid` is 0, `q_bit` is 1.
- R4: While `q_valid` is 1, `q_bit` equals bit (QW-1 - (frame_idx mod QW)) of the active value in force for the previous clock's frame. Frame slot 0 carries the MSB.
- R5: A write with `mf_en`=1 stores `q_wdata` in the shadow register and sets pending. The bits sent do not change before the next multiframe-start load.
- R6: The active register loads from the shadow only on the first clock of a `mf_start` pulse (a 0-to-1 change), and only when `mf_en`, `mf_sync` and pending are all 1. The loaded value already drives the bit for that same clock's frame index. The load clears pending. Further clocks of a held strobe do not load.
- R7: A multiframe start with nothing pending leaves the active value unchanged.
- R8: With `mf_en`=0, writes are ignored and no load happens.
- R9: With `mf_sync`=0, no load happens and a pending value is kept. It is loaded at the first multiframe start after synchronization returns.
- R10: When a write falls on the same clock as a load, the load takes the earlier shadow value. The new data stays pending for the next multiframe start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mf_en | input | 1 | Multiframing enabled |
| mf_sync | input | 1 | Multiframe synchronization found |
| frame_idx | input | FIDX_W | Frame index within the multiframe |
| mf_start | input | 1 | Multiframe-start strobe (may last more than one clock) |
| q_wr | input | 1 | New-Q write strobe from the control-channel decoder |
| q_wdata | input | QW | New Q value |
| q_bit | output | 1 | Q bit for the current frame, idle value 1 |
| q_valid | output | 1 | Q output is being sent |

## Verification
Several situations cannot be reached by a single pulse at the ports. The hardest are a write on the exact clock of a load edge, and a write during the later clocks of a held start strobe. The bench drives whole multiframes through a task that places the write strobe at a chosen frame slot and sets how many clocks the start strobe lasts. With that task it can aim a write at the load clock or at a later clock of the strobe. It then checks that the sent bits change only at the following multiframe. A separate sequence drops synchronization across a multiframe start while a write is pending. It confirms that nothing loads during that start and that the pending value appears after synchronization returns.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  localparam int unsigned QDB_QW_DEFAULT     = 4;
  localparam int unsigned QDB_FIDX_W_DEFAULT = 5;
  localparam logic        QDB_IDLE_BIT       = 1'b1;
endpackage

// File: rtl/qdb_shadow.sv
module qdb_shadow #(
  parameter int unsigned QW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ok,
  input  logic [QW-1:0] wr_data,
  input  logic          load,
  output logic [QW-1:0] shadow_q,
  output logic          pend_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '1;
      pend_q   <= 1'b0;
    end else begin
      if (wr_ok) shadow_q <= wr_data;
      if (wr_ok)     pend_q <= 1'b1;
      else if (load) pend_q <= 1'b0;
    end
  end

  assert_wr_captured_R5: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> (pend_q && shadow_q == $past(wr_data)));
  assert_load_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (load && !wr_ok) |=> !pend_q);
  assert_shadow_held_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_ok |=> $stable(shadow_q));
endmodule

// File: rtl/qdb_active.sv
module qdb_active #(
  parameter int unsigned QW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [QW-1:0] shadow,
  output logic [QW-1:0] act_q,
  output logic [QW-1:0] act_nxt
);
  always_comb act_nxt = load ? shadow : act_q;

  always_ff @(posedge clk) begin
    if (rst) act_q <= '1;
    else     act_q <= act_nxt;
  end

  assert_load_takes_shadow_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> (act_q == $past(shadow)));
  assert_hold_between_loads_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(act_q));
endmodule

// File: rtl/qdb_serial.sv
module qdb_serial #(
  parameter int unsigned QW     = 4,
  parameter int unsigned FIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send,
  input  logic [FIDX_W-1:0] frame_idx,
  input  logic [QW-1:0]     act_nxt,
  output logic              q_bit,
  output logic              q_valid
);
  import qdb_pkg::*;
  localparam int unsigned SEL_W = (QW > 1) ? $clog2(QW) : 1;

  logic [FIDX_W-1:0] slot_full;
  logic [SEL_W-1:0]  slot;
  logic              sel_bit;

  always_comb begin
    slot_full = frame_idx % FIDX_W'(QW);
    slot      = slot_full[SEL_W-1:0];
    sel_bit   = act_nxt[QW-1-int'(slot)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_bit   <= QDB_IDLE_BIT;
    end else begin
      q_valid <= send;
      q_bit   <= send ? sel_bit : QDB_IDLE_BIT;
    end
  end

  assert_idle_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    !q_valid |-> q_bit);
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q_valid == $past(send)));
endmodule

// File: rtl/qchan_dbuf.sv
module qchan_dbuf #(
  parameter int unsigned QW     = qdb_pkg::QDB_QW_DEFAULT,
  parameter int unsigned FIDX_W = qdb_pkg::QDB_FIDX_W_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mf_en,
  input  logic              mf_sync,
  input  logic [FIDX_W-1:0] frame_idx,
  input  logic              mf_start,
  input  logic              q_wr,
  input  logic [QW-1:0]     q_wdata,
  output logic              q_bit,
  output logic              q_valid
);
  logic          start_q;
  logic          start_edge;
  logic          load;
  logic          wr_ok;
  logic          send;
  logic          pend;
  logic [QW-1:0] shadow;
  logic [QW-1:0] act_q;
  logic [QW-1:0] act_nxt;

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= mf_start;
  end

  always_comb begin
    start_edge = mf_start & ~start_q;
    send       = mf_en & mf_sync;
    load       = start_edge & send & pend;
    wr_ok      = q_wr & mf_en;
  end

  qdb_shadow #(.QW(QW)) u_shadow (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .wr_data(q_wdata), .load(load),
    .shadow_q(shadow), .pend_q(pend)
  );

  qdb_active #(.QW(QW)) u_active (
    .clk(clk), .rst(rst), .load(load), .shadow(shadow),
    .act_q(act_q), .act_nxt(act_nxt)
  );

  qdb_serial #(.QW(QW), .FIDX_W(FIDX_W)) u_serial (
    .clk(clk), .rst(rst), .send(send), .frame_idx(frame_idx),
    .act_nxt(act_nxt), .q_bit(q_bit), .q_valid(q_valid)
  );

  assert_disabled_no_change_R8: assert property (@(posedge clk) disable iff (rst)
    !mf_en |=> ($stable(act_q) && $stable(shadow)));
  assert_unsynced_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (!mf_sync && !q_wr) |=> ($stable(act_q) && pend == $past(pend)));
  assert_held_strobe_no_load_R6: assert property (@(posedge clk) disable iff (rst)
    (mf_start && $past(mf_start)) |=> $stable(act_q));
  assert_nothing_pending_R7: assert property (@(posedge clk) disable iff (rst)
    (mf_start && !pend) |=> $stable(act_q));
endmodule

// File: tb/sim_qchan_dbuf.sv
module sim_qchan_dbuf;
  localparam int QW     = 4;
  localparam int FIDX_W = 5;
  localparam int MF_LEN = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mf_en = 1'b0, mf_sync = 1'b0, mf_start = 1'b0, q_wr = 1'b0;
  logic [FIDX_W-1:0] frame_idx = '0;
  logic [QW-1:0] q_wdata = '0;
  logic q_bit, q_valid;

  always #10 clk = ~clk;

  qchan_dbuf #(.QW(QW), .FIDX_W(FIDX_W)) u0 (
    .clk(clk), .rst(rst), .mf_en(mf_en), .mf_sync(mf_sync),
    .frame_idx(frame_idx), .mf_start(mf_start), .q_wr(q_wr),
    .q_wdata(q_wdata), .q_bit(q_bit), .q_valid(q_valid)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] expq[$];
  string tagq[$];

  logic [QW-1:0] m_sh, m_act;
  logic m_pend, m_prev;

  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) begin
      logic [1:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      checks++;
      if ({q_valid, q_bit} !== e) begin
        errors++;
        $display("FAIL %s: valid/bit actual %b%b expected %b%b", t, q_valid, q_bit, e[1], e[0]);
      end
    end
  end

  task automatic step(input logic en, input logic sync, input logic start,
                      input logic wr, input int idx, input logic [QW-1:0] data,
                      input string tag);
    logic edge_s, ld, v, b;
    logic [QW-1:0] actn;
    @(negedge clk);
    mf_en = en; mf_sync = sync; mf_start = start; q_wr = wr;
    frame_idx = FIDX_W'(idx); q_wdata = data;
    edge_s = start & ~m_prev;
    ld = edge_s & en & sync & m_pend;
    actn = ld ? m_sh : m_act;
    v = en & sync;
    b = v ? actn[QW-1-(idx % QW)] : 1'b1;
    expq.push_back({v, b});
    tagq.push_back(tag);
    m_act = actn;
    if (wr && en) begin m_sh = data; m_pend = 1'b1; end
    else if (ld) m_pend = 1'b0;
    m_prev = start;
  endtask

  task automatic mframe(input logic en, input logic sync, input int start_len,
                        input int wr_at, input logic [QW-1:0] data, input string tag);
    for (int f = 0; f < MF_LEN; f++)
      step(en, sync, f < start_len, f == wr_at, f, data, tag);
  endtask

  initial begin
    m_sh = '1; m_act = '1; m_pend = 1'b0; m_prev = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (q_valid !== 1'b0 || q_bit !== 1'b1) begin
      errors++;
      $display("FAIL R1: reset valid/bit actual %b%b expected 01", q_valid, q_bit);
    end
    @(negedge clk); rst = 1'b0;
    mframe(1, 1, 1, -1, 4'h0, "R1 idle ones after reset");
    mframe(1, 1, 1, 5, 4'hA, "R5 mid-multiframe write not applied");
    mframe(1, 1, 1, -1, 4'h0, "R4 R6 pattern 1010 after load");
    mframe(1, 1, 1, -1, 4'h0, "R7 no reload with nothing pending");
    mframe(1, 1, 3, 1, 4'h3, "R6 write during held strobe not loaded");
    mframe(1, 1, 1, -1, 4'h0, "R6 loaded at next rising strobe");
    mframe(0, 1, 1, 4, 4'h5, "R2 R3 R8 disabled output idle");
    mframe(1, 1, 1, -1, 4'h0, "R8 disabled write ignored");
    mframe(1, 1, 1, 7, 4'hC, "R5 pending write before sync loss");
    mframe(1, 0, 1, -1, 4'h0, "R9 no load while unsynced");
    mframe(1, 1, 1, -1, 4'h0, "R9 pending loaded after resync");
    mframe(1, 1, 1, 9, 4'h6, "R10 setup pending value");
    mframe(1, 1, 1, 0, 4'h9, "R10 write on load clock loads older value");
    mframe(1, 1, 1, -1, 4'h0, "R10 newer value at following start");
    mframe(1, 1, 1, -1, 4'h0, "R4 stable pattern");
    @(negedge clk);
    mf_en = 0; mf_sync = 0; mf_start = 0; q_wr = 0;
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule